// File: doc/BRIEF.md
# Frequency-Change Watchdog Recovery Controller

This block guards software-driven clock frequency changes. Every time software applies a new frequency setting, the block records the setting in a short history. If a non-zero timeout code is programmed at that moment, it also starts a seconds timer. If software confirms that the system survived the change by clearing the timeout code before the timer runs out, nothing else happens and the new frequency stays in effect.

If the timer runs out instead, the block raises an alarm status bit. It selects a fallback frequency source: either the hardware strap setting, or the software setting that was in use before the one that caused the hang. It also drives an active-low system reset pulse, provided the shared pin is configured as a reset output.

Seconds are counted from an external one-second tick. The reset pulse length is a parameter counted in system clocks.

Top module: `freq_wd_recover`

## Requirements
- R1: After reset, `alarm` is 0, `sys_rst_n` is 1, `freq_src` is 0 (software setting in force) and `prior_setting` is 0. Both history entries also reset to 0.
- R2: A `freq_apply` pulse taken while `tmo_code` is 0 starts no timer; any following number of ticks causes no expiry. Ticks that arrive while no timer runs have no effect.
- R3: A `freq_apply` pulse taken with `tmo_code` = N (1 to 15) starts a count. Expiry happens on the clock edge that samples the N-th `sec_tick` after the apply. `alarm` reads 1 from that edge on.
- R4: A `tmo_clear` pulse before expiry cancels the timer. No alarm, no reset pulse and no source change follow, however many ticks come after it.
- R5: A `tmo_clear` pulse returns `alarm` to 0 on the next edge.
- R6: At expiry with `revert_sel` = 0, `freq_src` becomes 1 (hardware strap setting).
- R7: At expiry with `revert_sel` = 1, `freq_src` becomes 2 (earlier software setting). `prior_setting` then holds the `sw_setting` applied just before the most recent one.
- R8: At expiry with `pin_is_stop` = 0, `sys_rst_n` is low for exactly PULSE_CYC clock cycles, starting on the expiry edge.
- R9: At expiry with `pin_is_stop` = 1, `sys_rst_n` stays high, while `alarm` is still set.
- R10: A `freq_apply` pulse while a timer runs restarts the count from zero, so expiry needs N further ticks.
- R11: The next `freq_apply` after a fallback returns `freq_src` to 0.
- R12: The timeout length is captured at the apply. Changing `tmo_code` afterwards without a clear does not change when expiry happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmo_code | input | 4 | Timeout in seconds; 0 disables |
| revert_sel | input | 1 | Fallback choice: 0 strap, 1 earlier software setting |
| pin_is_stop | input | 1 | 1: shared pin is a stop input, so no reset is driven |
| freq_apply | input | 1 | One-cycle pulse: new software frequency applied |
| sw_setting | input | SET_W | Setting being applied with `freq_apply` |
| tmo_clear | input | 1 | One-cycle pulse: timeout code rewritten to zero |
| sec_tick | input | 1 | One-cycle pulse per second |
| alarm | output | 1 | Timeout status bit |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| freq_src | output | 2 | 0 software, 1 strap, 2 earlier software setting |
| prior_setting | output | SET_W | Earlier software setting chosen by a fallback |

## Verification
The timer is driven in several ways:
- a zero code, which must never expire;
- codes of 3, 2, 4 and 6 seconds, where the exact tick of expiry separates an off-by-one count from a correct one;
- a clear before expiry, which separates cancellation from a mere alarm reset;
- a second apply in mid-count, which tells a restart from a continued count;
- a code change after the apply, which tells a captured limit from a live one.

Both fallback choices are tried, each with a different pin mode. This shows that the source selection and the reset gating act independently. The history contents show whether the stored value is the setting before the last one or the last one itself.

// File: rtl/fwr_pkg.sv
// Shared types for the frequency-change watchdog recovery controller.
package fwr_pkg;
    // Frequency source in force after the last event.
    typedef enum logic [1:0] {
        SRC_SOFT  = 2'd0,
        SRC_STRAP = 2'd1,
        SRC_PRIOR = 2'd2
    } fsrc_e;
endpackage

// File: rtl/fwr_sec_timer.sv
// Seconds timer armed by a frequency apply.
// It captures the timeout code when an apply arrives and counts sec_tick
// pulses. The expire output is a single-cycle pulse on the edge that samples
// the final tick.
// Assumes that apply, clear and tick are single-cycle pulses synchronous to
// clk. An apply takes priority over a clear in the same cycle.
module fwr_sec_timer #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] tmo_code,
    input  logic              apply,
    input  logic              clear,
    input  logic              tick,
    output logic              expire
);
    logic              armed;
    logic [CODE_W-1:0] cnt;
    logic [CODE_W-1:0] lim;

    // Last tick of a running count, unless an apply or clear preempts it.
    assign expire = armed && tick && !apply && !clear && (cnt == lim - 1'b1);

    // Arm, restart, cancel and advance the seconds count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
            lim   <= '0;
        end else if (apply) begin
            armed <= (tmo_code != '0);
            cnt   <= '0;
            lim   <= tmo_code;
        end else if (clear || expire) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (armed && tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (cnt < lim));
    // R2
    zero_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && tmo_code == '0) |=> !armed);
    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && tmo_code != '0) |=> (armed && cnt == '0));
    // R3
    expire_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !armed);
endmodule

// File: rtl/fwr_history.sv
// Two-deep history of applied software settings and the fallback source select.
// Each apply pushes the current setting into the earlier slot. At expiry, the
// revert choice picks either the strap source or the earlier setting, and the
// earlier setting is latched into prior_setting.
// Assumes that apply and expire never occur in the same cycle; the timer
// guarantees this.
module fwr_history
    import fwr_pkg::*;
#(
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply,
    input  logic [SET_W-1:0] setting,
    input  logic             expire,
    input  logic             revert_sel,
    output fsrc_e            freq_src,
    output logic [SET_W-1:0] prior_setting
);
    logic [SET_W-1:0] cur_q;
    logic [SET_W-1:0] prev_q;

    // Shift the history on each apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else if (apply) begin
            prev_q <= cur_q;
            cur_q  <= setting;
        end
    end

    // Choose the source at expiry; a new apply returns it to the software setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_src      <= SRC_SOFT;
            prior_setting <= '0;
        end else if (apply) begin
            freq_src <= SRC_SOFT;
        end else if (expire) begin
            if (revert_sel) begin
                freq_src      <= SRC_PRIOR;
                prior_setting <= prev_q;
            end else begin
                freq_src <= SRC_STRAP;
            end
        end
    end

    // R11
    apply_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (freq_src == SRC_SOFT));
    // R6
    strap_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !revert_sel) |=> (freq_src == SRC_STRAP));
    // R7
    prior_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && revert_sel) |=> (freq_src == SRC_PRIOR));
endmodule

// File: rtl/fwr_rst_pulse.sv
// Active-low reset pulse generator.
// A fire pulse with enable high loads a down-counter. The output is low
// while the counter is non-zero.
// Assumes PULSE_CYC >= 1.
module fwr_rst_pulse #(
    parameter int PULSE_CYC = 750_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic en,
    output logic rst_n_o
);
    localparam int PCNT_W = $clog2(PULSE_CYC + 1);

    logic [PCNT_W-1:0] pcnt;

    // Load on an enabled fire, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (fire && en) begin
            pcnt <= PCNT_W'(PULSE_CYC);
        end else if (pcnt != '0) begin
            pcnt <= pcnt - 1'b1;
        end
    end

    assign rst_n_o = (pcnt == '0);

    // R8
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && en) |=> !rst_n_o);
    // R9
    gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !en && rst_n_o) |=> rst_n_o);
endmodule

// File: rtl/freq_wd_recover.sv
// Frequency-change watchdog recovery controller (top).
// It connects the seconds timer, the setting history and the reset pulse
// generator, and it holds the alarm status bit.
// Assumes that all inputs are synchronous to clk and that the pulse inputs
// last one cycle.
module freq_wd_recover #(
    parameter int CODE_W    = 4,
    parameter int SET_W     = 8,
    parameter int PULSE_CYC = 750_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] tmo_code,
    input  logic              revert_sel,
    input  logic              pin_is_stop,
    input  logic              freq_apply,
    input  logic [SET_W-1:0]  sw_setting,
    input  logic              tmo_clear,
    input  logic              sec_tick,
    output logic              alarm,
    output logic              sys_rst_n,
    output logic [1:0]        freq_src,
    output logic [SET_W-1:0]  prior_setting
);
    import fwr_pkg::*;

    logic  expire;
    fsrc_e src_e;

    fwr_sec_timer #(.CODE_W(CODE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmo_code (tmo_code),
        .apply    (freq_apply),
        .clear    (tmo_clear),
        .tick     (sec_tick),
        .expire   (expire)
    );

    fwr_history #(.SET_W(SET_W)) u_hist (
        .clk           (clk),
        .rst_n         (rst_n),
        .apply         (freq_apply),
        .setting       (sw_setting),
        .expire        (expire),
        .revert_sel    (revert_sel),
        .freq_src      (src_e),
        .prior_setting (prior_setting)
    );

    fwr_rst_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (expire),
        .en      (!pin_is_stop),
        .rst_n_o (sys_rst_n)
    );

    assign freq_src = src_e;

    // Set the alarm at expiry and drop it on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm <= 1'b0;
        end else if (tmo_clear) begin
            alarm <= 1'b0;
        end else if (expire) begin
            alarm <= 1'b1;
        end
    end

    // R5
    clear_drops_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_clear |=> !alarm);
    // R6
    alarm_with_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> (freq_src != 2'd0));
endmodule

// File: tb/test_freq_wd_recover.sv
module test_freq_wd_recover;
    localparam int SET_W = 8;
    localparam int PULSE = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       tmo_code = '0;
    logic             revert_sel = 1'b0;
    logic             pin_is_stop = 1'b0;
    logic             freq_apply = 1'b0;
    logic [SET_W-1:0] sw_setting = '0;
    logic             tmo_clear = 1'b0;
    logic             sec_tick = 1'b0;
    logic             alarm;
    logic             sys_rst_n;
    logic [1:0]       freq_src;
    logic [SET_W-1:0] prior_setting;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    freq_wd_recover #(.SET_W(SET_W), .PULSE_CYC(PULSE)) i_freq_wd_recover (
        .clk(clk), .rst_n(rst_n), .tmo_code(tmo_code), .revert_sel(revert_sel),
        .pin_is_stop(pin_is_stop), .freq_apply(freq_apply), .sw_setting(sw_setting),
        .tmo_clear(tmo_clear), .sec_tick(sec_tick), .alarm(alarm),
        .sys_rst_n(sys_rst_n), .freq_src(freq_src), .prior_setting(prior_setting)
    );

    typedef struct {
        logic             a;
        logic             r;
        logic [1:0]       s;
        logic             chk_p;
        logic [SET_W-1:0] p;
        string            tag;
    } exp_t;

    exp_t sb[$];
    exp_t it;

    // Driver side: queue an expected output state for the current negedge.
    task automatic expect_out(input logic a, input logic r, input logic [1:0] s,
                              input logic chk_p, input logic [SET_W-1:0] p,
                              input string tag);
        exp_t e;
        e.a = a; e.r = r; e.s = s; e.chk_p = chk_p; e.p = p; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic apply(input logic [SET_W-1:0] v);
        @(negedge clk); freq_apply = 1'b1; sw_setting = v;
        @(negedge clk); freq_apply = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk); tmo_clear = 1'b1;
        @(negedge clk); tmo_clear = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 0;
    endtask

    // Monitor: compare queued expectations shortly after each negedge.
    always begin
        @(negedge clk);
        #1;
        while (sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (alarm !== it.a || sys_rst_n !== it.r || freq_src !== it.s ||
                (it.chk_p && prior_setting !== it.p)) begin
                failures++;
                $display("FAIL %s: got alarm=%0b rst_n=%0b src=%0d prior=%h exp alarm=%0b rst_n=%0b src=%0d prior=%h",
                         it.tag, alarm, sys_rst_n, freq_src, prior_setting,
                         it.a, it.r, it.s, it.p);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(0, 1, 0, 1, 8'h00, "R1 reset state");

        // R2: zero code, no timer
        tmo_code = 4'd0;
        apply(8'h11);
        for (int k = 0; k < 20; k++) tick();
        expect_out(0, 1, 0, 0, 0, "R2 zero code no expiry");

        // R3 R6 R8: 3 s, strap fallback, reset pin active
        tmo_code = 4'd3; revert_sel = 1'b0; pin_is_stop = 1'b0;
        apply(8'h22);
        tick(); tick();
        expect_out(0, 1, 0, 0, 0, "R3 no expiry before third tick");
        tick();
        expect_out(1, 0, 1, 0, 0, "R3 R6 R8 expiry on third tick");
        for (int k = 1; k < PULSE; k++) begin
            @(negedge clk);
            expect_out(1, 0, 1, 0, 0, "R8 reset held low");
        end
        @(negedge clk);
        expect_out(1, 1, 1, 0, 0, "R8 reset released after PULSE cycles");

        // R5 then R11
        clr();
        expect_out(0, 1, 1, 0, 0, "R5 clear drops alarm");
        tmo_code = 4'd0;
        apply(8'h33);
        expect_out(0, 1, 0, 0, 0, "R11 apply returns source to software");

        // R7 R9: 2 s, earlier software fallback, pin as stop input
        tmo_code = 4'd2; revert_sel = 1'b1; pin_is_stop = 1'b1;
        apply(8'h44);
        tick();
        expect_out(0, 1, 0, 0, 0, "R3 no expiry after first tick");
        tick();
        expect_out(1, 1, 2, 1, 8'h33, "R7 R9 expiry selects earlier setting");
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            expect_out(1, 1, 2, 1, 8'h33, "R9 no reset pulse in stop mode");
        end
        clr();

        // R4: clear before expiry cancels
        tmo_code = 4'd5; pin_is_stop = 1'b0; revert_sel = 1'b0;
        apply(8'h55);
        for (int k = 0; k < 4; k++) tick();
        clr();
        expect_out(0, 1, 0, 0, 0, "R4 cleared before expiry");
        for (int k = 0; k < 10; k++) tick();
        expect_out(0, 1, 0, 0, 0, "R4 no expiry after clear");

        // R10: restart in mid-count
        tmo_code = 4'd4;
        apply(8'h66);
        for (int k = 0; k < 3; k++) tick();
        apply(8'h77);
        for (int k = 0; k < 3; k++) tick();
        expect_out(0, 1, 0, 0, 0, "R10 restart delays expiry");
        tick();
        expect_out(1, 0, 1, 0, 0, "R10 expiry four ticks after restart");
        repeat (PULSE + 2) @(negedge clk);
        clr();

        // R12: limit captured at apply
        tmo_code = 4'd6;
        apply(8'h88);
        @(negedge clk); tmo_code = 4'd1;
        for (int k = 0; k < 5; k++) tick();
        expect_out(0, 1, 0, 0, 0, "R12 later code change ignored");
        tick();
        expect_out(1, 0, 1, 0, 0, "R12 expiry at captured limit");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule